// File: doc/BRIEF.md
# Reset Mode Latch and Vector Remap

This block decides the operating mode of a small controller at reset and applies it afterwards. While reset is held, it copies two board-level mode straps into three state bits: a boot ROM enable, a special (privileged) mode flag and an expanded-bus flag. A security fuse can force the expanded flag low, so a secured part only comes up in the plain single-chip mode or in the bootstrap mode. Once reset is released the straps are no longer looked at.

After reset the block sits between the CPU core and the memory decode. In a special mode it clears address bit 14 on every vector fetch, which moves the vector table from the top page down to the `$BFxx` page. It also raises a chip select for a 192-byte boot ROM window at `$BF40`-`$BFFF` while the boot ROM enable is set. Software can rewrite the mode bits only while the special flag is set. It may clear the special flag but can never set it again. When the part comes up in bootstrap mode, a reset-block flag is latched that tells the watchdog and clock monitor not to reset the part.

Top module: `bmode_top`

## Requirements
- R1: While `rstN` is low the mode register follows the straps, read as `regRdata` = {bootRom, special, expand} (bit 2, bit 1, bit 0). With (modePinB, modePinA) = (1,0) it reads 3'b000; (1,1) gives 3'b001; (0,0) gives 3'b110; (0,1) gives 3'b011.
- R2: Once `rstN` is high, changing `modePinA` or `modePinB` has no effect on `regRdata`.
- R3: When `fuseOpen` is 0, `modePinA` is treated as 0, so the expand bit resets to 0 and the reset mode is 3'b000 or 3'b110, chosen by `modePinB`.
- R4: `memAddr` equals `cpuAddr` in the same cycle, except that bit 14 is driven to 0 when `vecFetch` is 1 and the special bit is 1.
- R5: `bootRomSel` is 1 exactly when the boot ROM bit is 1 and `memAddr` lies in `$BF40`-`$BFFF`, in the same cycle.
- R6: While the special bit is 1, a cycle with `regWe` high loads `regWdata` (same bit layout as `regRdata`) into the mode register at that clock edge.
- R7: While the special bit is 0, writes leave `regRdata` unchanged and bit 2 of `regRdata` reads 0.
- R8: A write with bit 1 clear drops the special bit and the boot ROM bit. No later write can set the special bit again before the next reset.
- R9: `resetBlock` is 1 after a reset into the 3'b110 mode and 0 after any other reset. No write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the straps are captured while it is low |
| modePinA | input | 1 | Mode strap selecting the expanded bus |
| modePinB | input | 1 | Mode strap; low selects a special mode |
| fuseOpen | input | 1 | Security fuse; 0 means secured |
| regWe | input | 1 | Mode register write strobe |
| regWdata | input | 3 | Write data {bootRom, special, expand} |
| regRdata | output | 3 | Read data {bootRom, special, expand} |
| resetBlock | output | 1 | Suppress watchdog and clock-monitor resets |
| vecFetch | input | 1 | The current CPU access is a vector fetch |
| cpuAddr | input | 16 | Address from the CPU |
| memAddr | output | 16 | Address after the vector remap |
| bootRomSel | output | 1 | Boot ROM chip select |

## Verification
The address remap and the ROM select are purely combinational, so each is due in the same cycle as the address and fetch flag that cause it. The mode bits change at the first clock edge after a write strobe, and the reset values are in place at the first edge during reset. The scoreboard tags each expected item with the cycle in which it is due. The driver changes inputs on the falling edge, and the monitor compares one time unit later, only for items whose due cycle has arrived, so every sample falls after the rising edge that produced it.

// File: rtl/bmode_pkg.sv
package bmode_pkg;
  localparam int unsigned MODE_W = 3;

  typedef struct packed {
    logic bootRom;
    logic special;
    logic expand;
  } modeBits_t;

  typedef struct packed {
    logic remapEn;
    logic romEn;
  } ctlStrobe_t;
endpackage

// File: rtl/bmode_ctrl.sv
module bmode_ctrl
  import bmode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePinA,
  input  logic              modePinB,
  input  logic              fuseOpen,
  input  logic              regWe,
  input  logic [MODE_W-1:0] regWdata,
  output modeBits_t         modeQ,
  output logic              resetBlockQ,
  output ctlStrobe_t        strobe
);
  modeBits_t pinMode;
  modeBits_t wrMode;

  // decode of the straps; a secured part never sees the expand strap
  always_comb begin
    pinMode.expand  = modePinA & fuseOpen;
    pinMode.special = ~modePinB;
    pinMode.bootRom = ~modePinB & ~pinMode.expand;
  end

  // special may only be kept or dropped; boot ROM needs special
  always_comb begin
    wrMode.special = modeQ.special & regWdata[1];
    wrMode.expand  = regWdata[0];
    wrMode.bootRom = regWdata[2] & wrMode.special;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ       <= pinMode;
      resetBlockQ <= pinMode.bootRom;
    end else if (regWe && modeQ.special) begin
      modeQ <= wrMode;
    end
  end

  always_comb begin
    strobe.remapEn = modeQ.special;
    strobe.romEn   = modeQ.bootRom & modeQ.special;
  end
endmodule

// File: rtl/bmode_dpath.sv
module bmode_dpath
  import bmode_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        REMAP_BIT = 14,
  parameter logic [ADDR_W-1:0]  ROM_BASE  = 16'hBF40,
  parameter int unsigned        ROM_BYTES = 192
) (
  input  ctlStrobe_t        strobe,
  input  logic              vecFetch,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              bootRomSel
);
  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(ROM_BASE + ROM_BYTES - 1);

  logic clearBit;
  assign clearBit = strobe.remapEn & vecFetch;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i == REMAP_BIT) begin : g_remap
      assign memAddr[i] = cpuAddr[i] & ~clearBit;
    end else begin : g_pass
      assign memAddr[i] = cpuAddr[i];
    end
  end

  assign bootRomSel = strobe.romEn && (memAddr >= ROM_BASE) && (memAddr <= ROM_END);
endmodule

// File: rtl/bmode_top.sv
module bmode_top
  import bmode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modePinA,
  input  logic        modePinB,
  input  logic        fuseOpen,
  input  logic        regWe,
  input  logic [2:0]  regWdata,
  output logic [2:0]  regRdata,
  output logic        resetBlock,
  input  logic        vecFetch,
  input  logic [15:0] cpuAddr,
  output logic [15:0] memAddr,
  output logic        bootRomSel
);
  modeBits_t  modeQ;
  ctlStrobe_t strobe;

  bmode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modePinA(modePinA), .modePinB(modePinB),
    .fuseOpen(fuseOpen), .regWe(regWe), .regWdata(regWdata),
    .modeQ(modeQ), .resetBlockQ(resetBlock), .strobe(strobe)
  );

  bmode_dpath #(.ADDR_W(16), .REMAP_BIT(14), .ROM_BASE(16'hBF40), .ROM_BYTES(192)) u_dpath (
    .strobe(strobe), .vecFetch(vecFetch), .cpuAddr(cpuAddr),
    .memAddr(memAddr), .bootRomSel(bootRomSel)
  );

  assign regRdata = {modeQ.bootRom & modeQ.special, modeQ.special, modeQ.expand};
endmodule

// File: rtl/bmode_chk.sv
module bmode_chk (
  input logic        clk,
  input logic        rstN,
  input logic        modePinA,
  input logic        modePinB,
  input logic        fuseOpen,
  input logic        regWe,
  input logic [2:0]  regWdata,
  input logic [2:0]  regRdata,
  input logic        resetBlock,
  input logic        vecFetch,
  input logic [15:0] cpuAddr,
  input logic [15:0] memAddr,
  input logic        bootRomSel
);
  // R2
  straps_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(regRdata));
  // R7
  normal_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[1] |=> $stable(regRdata));
  // R7
  normal_rom_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[1] |-> !regRdata[2]);
  // R8
  no_special_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[1] |=> !regRdata[1]);
  // R4
  vec_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && regRdata[1]) |-> (!memAddr[14] && memAddr[13:0] == cpuAddr[13:0]
                                   && memAddr[15] == cpuAddr[15]));
  // R4
  no_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecFetch |-> memAddr == cpuAddr);
  // R5
  rom_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootRomSel |-> (regRdata[2] && memAddr[15:8] == 8'hBF && memAddr[7:6] != 2'b00));
  // R9
  reset_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(resetBlock));
endmodule

bind bmode_top bmode_chk u_chk (.*);

// File: tb/sim_bmode_top.sv
module sim_bmode_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        modePinA = 0, modePinB = 1, fuseOpen = 1;
  logic        regWe = 0;
  logic [2:0]  regWdata = 0;
  logic [2:0]  regRdata;
  logic        resetBlock;
  logic        vecFetch = 0;
  logic [15:0] cpuAddr = 0;
  logic [15:0] memAddr;
  logic        bootRomSel;

  always #2 clk = ~clk; // 250 MHz

  bmode_top u0 (.*);

  typedef struct {
    int          req;
    int          fld;   // 0 regRdata, 1 memAddr, 2 bootRomSel, 3 resetBlock
    logic [15:0] val;
    int          due;
  } item_t;

  item_t q[$];
  int cyc = 0, nTests = 0, nFails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pick(int fld);
    case (fld)
      0: return {13'd0, regRdata};
      1: return memAddr;
      2: return {15'd0, bootRomSel};
      default: return {15'd0, resetBlock};
    endcase
  endfunction

  // monitor: compare every item whose due cycle has come
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = pick(it.fld);
      nTests++;
      if (act !== it.val) begin
        nFails++;
        $display("FAIL R%0d field %0d: actual %h expected %h", it.req, it.fld, act, it.val);
      end
    end
  end

  task automatic expectItem(int req, int fld, logic [15:0] v, int lag);
    item_t it;
    it.req = req; it.fld = fld; it.val = v; it.due = cyc + lag;
    q.push_back(it);
  endtask

  function automatic logic [2:0] modeOf(logic b, logic a, logic sec);
    logic ea;
    ea = a & sec;
    case ({b, ea})
      2'b10: return 3'b000;
      2'b11: return 3'b001;
      2'b00: return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  task automatic doReset(int req, logic b, logic a, logic sec);
    @(negedge clk);
    rstN = 0; modePinB = b; modePinA = a; fuseOpen = sec; regWe = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    expectItem(req, 0, {13'd0, modeOf(b, a, sec)}, 0);
    expectItem(9, 3, {15'd0, modeOf(b, a, sec) == 3'b110}, 0); // R9
  endtask

  task automatic doWrite(logic [2:0] d);
    @(negedge clk);
    regWe = 1; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic doAddr(logic vec, logic [15:0] a);
    @(negedge clk);
    vecFetch = vec; cpuAddr = a;
  endtask

  initial begin
    // R1 single-chip
    doReset(1, 1, 0, 1);
    // R1 expanded
    doReset(1, 1, 1, 1);
    // R2 straps moved after release
    @(negedge clk); modePinB = 0; modePinA = 0;
    repeat (2) @(negedge clk);
    expectItem(2, 0, 16'h0001, 0);
    // R1 bootstrap, R9 set
    doReset(1, 0, 0, 1);
    // R4 vector remapped
    doAddr(1, 16'hFFFE); expectItem(4, 1, 16'hBFFE, 0); expectItem(5, 2, 16'h1, 0);
    // R4 non-vector passes
    doAddr(0, 16'hFFFE); expectItem(4, 1, 16'hFFFE, 0); expectItem(5, 2, 16'h0, 0);
    // R5 window edges
    doAddr(0, 16'hBF3F); expectItem(5, 2, 16'h0, 0);
    doAddr(0, 16'hBF40); expectItem(5, 2, 16'h1, 0);
    doAddr(0, 16'hBFFF); expectItem(5, 2, 16'h1, 0);
    doAddr(0, 16'hC000); expectItem(5, 2, 16'h0, 0);
    // R6 privileged write
    doWrite(3'b111); expectItem(6, 0, 16'h0007, 0);
    expectItem(9, 3, 16'h1, 0); // R9 unchanged by write
    // R8 drop special, boot follows
    doWrite(3'b001); expectItem(8, 0, 16'h0001, 0);
    // R8 cannot set again
    doWrite(3'b111); expectItem(8, 0, 16'h0001, 0);
    doAddr(1, 16'hFFFE); expectItem(4, 1, 16'hFFFE, 0);
    doAddr(0, 16'hBF40); expectItem(5, 2, 16'h0, 0);
    // R1 test mode
    doReset(1, 0, 1, 1);
    doAddr(1, 16'hFFFA); expectItem(4, 1, 16'hBFFA, 0);
    doAddr(0, 16'hBF40); expectItem(5, 2, 16'h0, 0);
    // R6 enable boot ROM from test mode
    doWrite(3'b110); expectItem(6, 0, 16'h0006, 0);
    doAddr(0, 16'hBF40); expectItem(5, 2, 16'h1, 0);
    // R3 secured part
    doReset(3, 1, 1, 0);
    doReset(3, 0, 1, 0);
    // R7 normal mode ignores writes
    doReset(1, 1, 0, 1);
    doWrite(3'b111); expectItem(7, 0, 16'h0000, 0);
    doAddr(1, 16'hFFFE); expectItem(4, 1, 16'hFFFE, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule